// File: doc/BRIEF.md
# Descriptor-Table Scatter List Walker

This block turns one command's table of physical region descriptors into a stream of address/length segments that cover a chosen byte window. The caller supplies the table base address, the number of descriptors, a starting byte offset into the data the table describes, and either a plain byte limit or a 16-bit sector count for a queued command. The walker fetches descriptors one at a time through a synchronous read port, skips whole entries that lie before the starting offset, then emits segments under a valid/ready handshake. Each segment is clipped so the total never passes the limit.

When the walk ends, a one-cycle `done` pulse marks the moment the byte total, the error flag and the short-table flag are valid. These three outputs then hold until the next start. A zero descriptor count, an offset past the end of the table, or a total above a configurable ceiling raises the error flag. A queued command whose table covers fewer bytes than the sector count asks for raises the short-table flag.

The controller has five states. `ST_IDLE` waits for `start`. It goes to `ST_DONE` on a zero count or a zero limit, and otherwise to `ST_FETCH`. `ST_FETCH` issues one descriptor read and always moves to `ST_WAIT`. In `ST_WAIT` the returned descriptor is evaluated. An entry that lies wholly before the offset returns the walker to `ST_FETCH`, or sends it to `ST_DONE` if that entry was the last one. A hit moves to `ST_EMIT`, unless it would break the ceiling, in which case the walker goes to `ST_DONE`. `ST_EMIT` holds the segment until `seg_ready`. It then returns to `ST_FETCH`, or goes to `ST_DONE` after the last segment. `ST_DONE` lasts one cycle and returns to `ST_IDLE`.

Top module: `sg_walker`

## Requirements
- R1: After reset, `seg_valid`, `done`, `rd_en`, `err` and `short_err` are all low.
- R2: Descriptor k is read at address `tbl_base + 0x80 + 16*k`. `rd_en` lasts one cycle per read, and the descriptor data is taken on the cycle after `rd_en`.
- R3: The length word is zero-based. An entry covers (`rd_len` bits [LEN_W-1:0]) + 1 bytes, and the length bits above LEN_W are ignored.
- R4: The first segment comes from the first entry whose running byte sum plus its own size is strictly greater than `start_off`. The segment starts at that entry's address plus the part of the offset that falls inside it. An offset exactly on an entry boundary therefore starts at the next entry's base.
- R5: Each segment's length is the smaller of the bytes left in its entry and the limit minus the bytes already emitted. The walk ends at the last entry or when the total equals the limit. `seg_last` marks the final segment, and the total never exceeds the limit.
- R6: Segments appear in table order, one per handshake. While `seg_ready` is low, a pending segment holds its address, length and last flag unchanged. No segment has length zero.
- R7: When `queued` is high, the limit is `sect_cnt` × 512, with a count of 0 meaning 65536 sectors, and `byte_limit` is ignored.
- R8: For a queued command whose emitted total ends below the limit, `short_err` is set. A non-queued walk never sets `short_err`.
- R9: A descriptor count of zero sets `err`. No segment is emitted and no descriptor is read.
- R10: A starting offset at or beyond the summed size of all entries sets `err`, and no segment is emitted.
- R11: If a segment would lift the total above MAX_TOTAL, that segment is not emitted and `err` is set. No emitted segment of that walk carries `seg_last`.
- R12: `done` is a single-cycle pulse. `total_bytes`, `err` and `short_err` hold after it until the next `start`. A non-queued walk with a zero limit finishes with no segment and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk; accepted in idle |
| queued | input | 1 | Limit comes from the sector count |
| sect_cnt | input | 16 | Sector count for queued commands (0 = 65536) |
| byte_limit | input | LIM_W | Byte limit for non-queued walks |
| start_off | input | LIM_W | Starting byte offset into the table's data |
| desc_cnt | input | CNT_W | Number of descriptors |
| tbl_base | input | ADDR_W | Command table base address |
| rd_en | output | 1 | Descriptor read strobe |
| rd_addr | output | ADDR_W | Descriptor read address |
| rd_base | input | ADDR_W | Descriptor data address, one cycle after `rd_en` |
| rd_len | input | 32 | Descriptor length word, one cycle after `rd_en` |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Consumer accepts the segment |
| seg_addr | output | ADDR_W | Segment start address |
| seg_len | output | LIM_W | Segment length in bytes |
| seg_last | output | 1 | Final segment of the walk |
| done | output | 1 | Walk finished (one cycle) |
| total_bytes | output | LIM_W | Bytes emitted by the walk |
| err | output | 1 | Count, offset or ceiling error |
| short_err | output | 1 | Queued table shorter than requested size |

## Verification
The bench sets MAX_TOTAL to 3000 instead of 2 GiB. With that ceiling, a four-entry table of 3840 bytes reaches the ceiling error within a few descriptors, where the default would need gigabytes of descriptors. The address, length and count widths stay at their defaults. The queued limit therefore runs across the full 16-bit sector range, including the zero-means-65536 case, which leaves the short-table flag set against a table of under 2 KiB. Stalling `seg_ready` on two of every three cycles exposes the hold behaviour of a pending segment.

// File: rtl/sg_walk_pkg.sv
package sg_walk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_EMIT,
        ST_DONE
    } walk_state_e;

    // descriptor table placement relative to the command table base
    localparam int unsigned TABLE_OFS   = 32'h80;
    localparam int unsigned DESC_SHIFT  = 4;

endpackage

// File: rtl/sg_limit_calc.sv
module sg_limit_calc #(
    parameter int LIM_W = 32
) (
    input  logic             queued,
    input  logic [15:0]      sect_cnt,
    input  logic [LIM_W-1:0] byte_limit,
    output logic [LIM_W-1:0] limit
);
    localparam int SECT_SHIFT = 9;

    logic [16:0] sectors;

    // a zero count stands for the full 65536-sector range
    assign sectors = {(sect_cnt == 16'd0), sect_cnt};
    assign limit   = queued ? LIM_W'({sectors, {SECT_SHIFT{1'b0}}}) : byte_limit;

endmodule

// File: rtl/sg_seg_calc.sv
module sg_seg_calc #(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 22,
    parameter int SUM_W  = 39,
    parameter int LIM_W  = 32
) (
    input  logic              found,
    input  logic [LIM_W-1:0]  offset,
    input  logic [SUM_W-1:0]  sum,
    input  logic [LIM_W-1:0]  tot,
    input  logic [LIM_W-1:0]  limit,
    input  logic [ADDR_W-1:0] d_base,
    input  logic [31:0]       d_len,
    output logic              hit,
    output logic [SUM_W-1:0]  size,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [LIM_W-1:0]  seg_len
);
    localparam logic [31:0] LEN_MASK = 32'((64'd1 << LEN_W) - 64'd1);

    logic [SUM_W-1:0] off_w;
    logic [SUM_W-1:0] skip;
    logic [SUM_W-1:0] avail;
    logic [SUM_W-1:0] room;

    always_comb begin
        size     = SUM_W'(d_len & LEN_MASK) + SUM_W'(1);
        off_w    = SUM_W'(offset);
        hit      = found || (off_w < (sum + size));
        skip     = found ? '0 : (off_w - sum);
        avail    = size - skip;
        room     = SUM_W'(limit - tot);
        seg_len  = LIM_W'((avail < room) ? avail : room);
        seg_addr = d_base + ADDR_W'(skip);
    end

endmodule

// File: rtl/sg_walker.sv
module sg_walker
    import sg_walk_pkg::*;
#(
    parameter int          ADDR_W    = 64,
    parameter int          LEN_W     = 22,
    parameter int          CNT_W     = 16,
    parameter int          LIM_W     = 32,
    parameter logic [63:0] MAX_TOTAL = 64'h8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              queued,
    input  logic [15:0]       sect_cnt,
    input  logic [LIM_W-1:0]  byte_limit,
    input  logic [LIM_W-1:0]  start_off,
    input  logic [CNT_W-1:0]  desc_cnt,
    input  logic [ADDR_W-1:0] tbl_base,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] rd_base,
    input  logic [31:0]       rd_len,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [LIM_W-1:0]  seg_len,
    output logic              seg_last,
    output logic              done,
    output logic [LIM_W-1:0]  total_bytes,
    output logic              err,
    output logic              short_err
);
    localparam int SUM_W = ((LEN_W + CNT_W + 1) > LIM_W) ? (LEN_W + CNT_W + 1) : LIM_W;

    walk_state_e state_q, state_d;

    logic [CNT_W-1:0]  idx_q, cnt_q;
    logic [SUM_W-1:0]  sum_q;
    logic [LIM_W-1:0]  tot_q, lim_q, off_q;
    logic [ADDR_W-1:0] base_q;
    logic              queued_q, found_q;
    logic [ADDR_W-1:0] sa_q;
    logic [LIM_W-1:0]  sl_q;
    logic              last_q, err_q, short_q;

    logic [LIM_W-1:0]  limit_w;
    logic              hit_w;
    logic [SUM_W-1:0]  size_w;
    logic [ADDR_W-1:0] caddr_w;
    logic [LIM_W-1:0]  clen_w;
    logic              last_entry;
    logic              over_w;
    logic              fills_w;

    sg_limit_calc #(.LIM_W(LIM_W)) u_limit (
        .queued     (queued),
        .sect_cnt   (sect_cnt),
        .byte_limit (byte_limit),
        .limit      (limit_w)
    );

    sg_seg_calc #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .SUM_W  (SUM_W),
        .LIM_W  (LIM_W)
    ) u_seg (
        .found    (found_q),
        .offset   (off_q),
        .sum      (sum_q),
        .tot      (tot_q),
        .limit    (lim_q),
        .d_base   (rd_base),
        .d_len    (rd_len),
        .hit      (hit_w),
        .size     (size_w),
        .seg_addr (caddr_w),
        .seg_len  (clen_w)
    );

    assign last_entry = (idx_q == (cnt_q - CNT_W'(1)));
    assign over_w     = (64'(tot_q) + 64'(clen_w)) > MAX_TOTAL;
    assign fills_w    = ((tot_q + clen_w) == lim_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)
                          state_d = ((desc_cnt == '0) || (limit_w == '0)) ? ST_DONE : ST_FETCH;
            ST_FETCH: state_d = ST_WAIT;
            ST_WAIT:  if (!hit_w) state_d = last_entry ? ST_DONE : ST_FETCH;
                      else        state_d = over_w ? ST_DONE : ST_EMIT;
            ST_EMIT:  if (seg_ready) state_d = last_q ? ST_DONE : ST_FETCH;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_en       = (state_q == ST_FETCH);
        rd_addr     = base_q + ADDR_W'(TABLE_OFS) + (ADDR_W'(idx_q) << DESC_SHIFT);
        seg_valid   = (state_q == ST_EMIT);
        seg_addr    = sa_q;
        seg_len     = sl_q;
        seg_last    = last_q;
        done        = (state_q == ST_DONE);
        total_bytes = tot_q;
        err         = err_q;
        short_err   = short_q;
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            cnt_q    <= '0;
            sum_q    <= '0;
            tot_q    <= '0;
            lim_q    <= '0;
            off_q    <= '0;
            base_q   <= '0;
            queued_q <= 1'b0;
            found_q  <= 1'b0;
            sa_q     <= '0;
            sl_q     <= '0;
            last_q   <= 1'b0;
            err_q    <= 1'b0;
            short_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    idx_q    <= '0;
                    cnt_q    <= desc_cnt;
                    sum_q    <= '0;
                    tot_q    <= '0;
                    lim_q    <= limit_w;
                    off_q    <= start_off;
                    base_q   <= tbl_base;
                    queued_q <= queued;
                    found_q  <= 1'b0;
                    last_q   <= 1'b0;
                    err_q    <= (desc_cnt == '0);
                    short_q  <= 1'b0;
                end
                ST_WAIT: begin
                    if (!hit_w) begin
                        sum_q <= sum_q + size_w;
                        idx_q <= idx_q + CNT_W'(1);
                        if (last_entry) err_q <= 1'b1;
                    end else begin
                        found_q <= 1'b1;
                        if (over_w) begin
                            err_q <= 1'b1;
                        end else begin
                            sa_q   <= caddr_w;
                            sl_q   <= clen_w;
                            last_q <= last_entry || fills_w;
                        end
                    end
                end
                ST_EMIT: if (seg_ready) begin
                    tot_q <= tot_q + sl_q;
                    idx_q <= idx_q + CNT_W'(1);
                    if (last_q) short_q <= queued_q && ((tot_q + sl_q) < lim_q);
                end
                default: ;
            endcase
        end
    end

    // R6
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_last));

    // R6
    seg_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> seg_len != '0);

    // R5
    tot_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> total_bytes <= lim_q);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en && !seg_valid);

    // R8
    short_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && short_err |-> !err);

endmodule

// File: tb/sg_walker_tb.sv
module sg_walker_tb;
    localparam int          ADDR_W = 64;
    localparam int          LIM_W  = 32;
    localparam int          CNT_W  = 16;
    localparam logic [63:0] TBASE  = 64'h1000_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              queued = 1'b0;
    logic [15:0]       sect_cnt = '0;
    logic [LIM_W-1:0]  byte_limit = '0;
    logic [LIM_W-1:0]  start_off = '0;
    logic [CNT_W-1:0]  desc_cnt = '0;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] rd_base;
    logic [31:0]       rd_len;
    logic              seg_valid;
    logic              seg_ready = 1'b0;
    logic [ADDR_W-1:0] seg_addr;
    logic [LIM_W-1:0]  seg_len;
    logic              seg_last;
    logic              done;
    logic [LIM_W-1:0]  total_bytes;
    logic              err;
    logic              short_err;

    int checks = 0;
    int fails  = 0;

    logic [63:0] got_addr [0:7];
    logic [63:0] got_len  [0:7];
    logic        got_last [0:7];
    int          nseg;
    int          nrd;
    int          bad_rd;

    logic [63:0] t_base [0:3];
    logic [31:0] t_len  [0:3];
    logic [63:0] ram_off;

    always #4 clk = ~clk;

    sg_walker #(.MAX_TOTAL(64'd3000)) u_dut (
        .clk, .rst_n, .start, .queued, .sect_cnt, .byte_limit, .start_off,
        .desc_cnt, .tbl_base(TBASE), .rd_en, .rd_addr, .rd_base, .rd_len,
        .seg_valid, .seg_ready, .seg_addr, .seg_len, .seg_last, .done,
        .total_bytes, .err, .short_err
    );

    // descriptor memory, one-cycle synchronous read
    assign ram_off = rd_addr - TBASE - 64'h80;
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_base <= t_base[ram_off[5:4]];
            rd_len  <= t_len[ram_off[5:4]];
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic run_walk(input logic q, input logic [15:0] sc, input logic [31:0] bl,
                            input logic [31:0] off, input logic [15:0] cnt, input bit stall);
        int cyc;
        logic [31:0] tot_seen;
        nseg = 0; nrd = 0; bad_rd = 0; cyc = 0;
        @(negedge clk);
        queued = q; sect_cnt = sc; byte_limit = bl; start_off = off; desc_cnt = cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (1) begin
            seg_ready = stall ? (cyc % 3 == 2) : 1'b1;
            #1;
            if (seg_valid && seg_ready && nseg < 8) begin
                got_addr[nseg] = seg_addr;
                got_len[nseg]  = 64'(seg_len);
                got_last[nseg] = seg_last;
                nseg++;
            end
            if (rd_en) begin
                nrd++;
                if (ram_off[3:0] != 4'd0 || ram_off[63:6] != '0) bad_rd++;
            end
            if (done) break;
            cyc++;
            if (cyc > 500) begin
                chk("watchdog walk", 64'd0, 64'd1);
                break;
            end
            @(negedge clk);
        end
        tot_seen = total_bytes;
        @(negedge clk);
        // R12: single-cycle done, results held
        chk("R12 done pulse", 64'(done), 64'd0);
        chk("R12 total held", 64'(total_bytes), 64'(tot_seen));
        // R2: every read aligned inside the table
        chk("R2 read address", 64'(bad_rd), 64'd0);
    endtask

    task automatic expect_seg(input string req, input int i, input logic [63:0] a,
                              input logic [63:0] l, input logic last);
        chk({req, " addr"}, got_addr[i], a);
        chk({req, " len"},  got_len[i], l);
        chk({req, " last"}, 64'(got_last[i]), 64'(last));
    endtask

    task automatic expect_end(input string req, input int n, input logic [31:0] tot,
                              input logic e, input logic s);
        chk({req, " segments"}, 64'(nseg), 64'(n));
        chk({req, " total"}, 64'(total_bytes), 64'(tot));
        chk({req, " err"}, 64'(err), 64'(e));
        chk({req, " short"}, 64'(short_err), 64'(s));
    endtask

    task automatic t_reset;
        chk("R1 seg_valid", 64'(seg_valid), 0);
        chk("R1 done", 64'(done), 0);
        chk("R1 rd_en", 64'(rd_en), 0);
        chk("R1 err", 64'(err), 0);
        chk("R1 short", 64'(short_err), 0);
    endtask

    task automatic t_basic;   // R3 R5 R8: masked length, end of table, no short flag
        run_walk(1'b0, 16'd0, 32'd10000, 32'd0, 16'd3, 1'b0);
        expect_seg("R5 basic s0", 0, 64'h1000, 64'd512, 1'b0);
        expect_seg("R5 basic s1", 1, 64'h8000, 64'd1024, 1'b0);
        expect_seg("R3 masked s2", 2, 64'h20000, 64'd256, 1'b1);
        expect_end("R8 nonqueued", 3, 32'd1792, 1'b0, 1'b0);
        chk("R2 read count", 64'(nrd), 64'd3);
    endtask

    task automatic t_offset;  // R4 R5 R6 with stalls
        run_walk(1'b0, 16'd0, 32'd1000, 32'd700, 16'd4, 1'b1);
        expect_seg("R4 offset s0", 0, 64'h80BC, 64'd836, 1'b0);
        expect_seg("R6 clipped s1", 1, 64'h20000, 64'd164, 1'b1);
        expect_end("R5 offset", 2, 32'd1000, 1'b0, 1'b0);
    endtask

    task automatic t_boundary;  // R4 boundary is exclusive
        run_walk(1'b0, 16'd0, 32'd100, 32'd512, 16'd4, 1'b0);
        expect_seg("R4 boundary", 0, 64'h8000, 64'd100, 1'b1);
        expect_end("R4 boundary", 1, 32'd100, 1'b0, 1'b0);
    endtask

    task automatic t_queued;  // R7: 2 sectors, byte_limit ignored
        run_walk(1'b1, 16'd2, 32'd5, 32'd0, 16'd4, 1'b1);
        expect_seg("R7 queued s0", 0, 64'h1000, 64'd512, 1'b0);
        expect_seg("R7 queued s1", 1, 64'h8000, 64'd512, 1'b1);
        expect_end("R7 queued", 2, 32'd1024, 1'b0, 1'b0);
    endtask

    task automatic t_short;   // R8
        run_walk(1'b1, 16'd4, 32'd0, 32'd0, 16'd3, 1'b0);
        expect_seg("R8 short last", 2, 64'h20000, 64'd256, 1'b1);
        expect_end("R8 short", 3, 32'd1792, 1'b0, 1'b1);
    endtask

    task automatic t_zero_sect;  // R7: zero sectors means 65536
        run_walk(1'b1, 16'd0, 32'd0, 32'd0, 16'd3, 1'b0);
        expect_end("R7 zero sectors", 3, 32'd1792, 1'b0, 1'b1);
    endtask

    task automatic t_zero_cnt;  // R9
        run_walk(1'b0, 16'd0, 32'd1000, 32'd0, 16'd0, 1'b0);
        expect_end("R9 zero count", 0, 32'd0, 1'b1, 1'b0);
        chk("R9 no reads", 64'(nrd), 64'd0);
    endtask

    task automatic t_past_end;  // R10
        run_walk(1'b0, 16'd0, 32'd1000, 32'd3840, 16'd4, 1'b0);
        expect_end("R10 offset past end", 0, 32'd0, 1'b1, 1'b0);
    endtask

    task automatic t_ceiling;  // R11
        run_walk(1'b0, 16'd0, 32'd10000, 32'd0, 16'd4, 1'b0);
        expect_end("R11 ceiling", 3, 32'd1792, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++)
            chk("R11 no last", 64'(got_last[i]), 64'd0);
    endtask

    task automatic t_zero_limit;  // R12
        run_walk(1'b0, 16'd0, 32'd0, 32'd0, 16'd4, 1'b0);
        expect_end("R12 zero limit", 0, 32'd0, 1'b0, 1'b0);
    endtask

    initial begin
        t_base[0] = 64'h1000;  t_len[0] = 32'h0000_01FF;
        t_base[1] = 64'h8000;  t_len[1] = 32'h0000_03FF;
        t_base[2] = 64'h20000; t_len[2] = 32'h8000_00FF;
        t_base[3] = 64'h40000; t_len[3] = 32'h0000_07FF;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_offset();
        t_boundary();
        t_queued();
        t_short();
        t_zero_sect();
        t_zero_cnt();
        t_past_end();
        t_ceiling();
        t_basic();
        t_zero_limit();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule